// File: doc/BRIEF.md
# Periodic Compare-Window Pulse Generator

This block divides a stream of count events into fixed-length frames and raises a window output for a chosen number of counts in each frame. A typical setting uses a count rate of 1 MHz, a frame length of 1,000,000 counts and a window of 300,000 counts. That gives a 300 ms high pulse once every second, together with a terminal-count strobe that marks the last count of every frame. The counter is 24 bits wide by default.

Counting is driven by the rising edges of a count input, which the block clock samples. A level held high does not count, so a clock divided by two can be fed in to count on every second block clock. The count direction sets where the window sits. When counting up, the window leads the frame. When counting down, the window trails it. The frame length, the window length and the direction come from static configuration ports. They are captured only at reset and at each reload, so a change made partway through a frame first applies to the next frame.

Top module: `cwp_pulse_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the counter loads its start value and captures the configuration. The start value is 0 when `dir_down` is 0 and P-1 when `dir_down` is 1. Right after release, `win_o` equals (start < C) and `tc_o` equals (start is the terminal value). Toggling `cnt_in` while `rst` is high has no effect.
- R2: One count step takes place at the second clock edge after `cnt_in` is first sampled high following a sample of 0. A level held high or held low never steps the counter. After reset, `cnt_in` must be sampled low once before a rising edge can count.
- R3: When `dir_down` = 0 (up mode), the count runs 0, 1, …, P-1 and then reloads to 0.
- R4: When `dir_down` = 1 (down mode), the count runs P-1, P-2, …, 0 and then reloads to P-1.
- R5: `tc_o` is high exactly while the count holds the terminal value, which is P-1 in up mode and 0 in down mode. It therefore covers one count interval per frame. A step taken at the terminal value always reloads the counter and never counts past it.
- R6: `win_o` is high exactly while the count is below C. In up mode this gives a window over the first C counts of the frame. In down mode it gives a window over the last C counts.
- R7: P, C and the direction are captured only at reset and at reload. A change on `cfg_period`, `cfg_cmp` or `dir_down` in mid-frame takes effect from the next frame onward.
- R8: When C = 0, `win_o` stays low. When C ≥ P, `win_o` stays high.
- R9: Both outputs are registered. They change only at the clock edge that performs a count step or a reset load.
- R10: A `cfg_period` of 0 behaves as a period of 1. The count never leaves the range 0 to P-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high; must be low for counting |
| cnt_in | input | 1 | Count input, stepped on rising edges sampled by `clk` |
| dir_down | input | 1 | Count direction: 0 up (leading window), 1 down (trailing window) |
| cfg_period | input | CNT_W | Frame length P in counts |
| cfg_cmp | input | CNT_W | Window length C in counts |
| win_o | output | 1 | Compare-window pulse, registered |
| tc_o | output | 1 | Terminal-count indication, registered |

## Verification
The assertions assume that `cnt_in` is already synchronous to `clk` and does not change close to the sampling edge. They also assume a reset is applied before operation starts. The bench meets these assumptions by changing `cnt_in` and the configuration only at falling clock edges. It also starts every scenario with a reset and keeps `cnt_in` low for one sample after reset before producing any rising edge. The configuration ports are changed in mid-frame only on purpose, to show that the new values wait until the next reload.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
    localparam int unsigned CWP_CNT_W = 24;

    typedef enum logic {
        CWP_DIR_UP   = 1'b0,
        CWP_DIR_DOWN = 1'b1
    } cwp_dir_e;
endpackage

// File: rtl/cwp_edge_det.sv
module cwp_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    typedef struct packed {
        logic cur;
        logic prv;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cur = lvl_i;
        st_d.prv = st_q.cur;
        if (rst) begin
            // both taps high: a level held through reset is not an edge
            st_d.cur = 1'b1;
            st_d.prv = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rise_o = st_q.cur & ~st_q.prv;
endmodule

// File: rtl/cwp_cfg_hold.sv
module cwp_cfg_hold
    import cwp_pkg::*;
#(
    parameter int unsigned W = CWP_CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] per_i,
    input  logic [W-1:0] cmp_i,
    input  cwp_dir_e     dir_i,
    output logic [W-1:0] cur_last_o,
    output logic [W-1:0] cur_cmp_o,
    output cwp_dir_e     cur_dir_o,
    output logic [W-1:0] nxt_last_o,
    output logic [W-1:0] nxt_cmp_o,
    output cwp_dir_e     nxt_dir_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] last;
        logic [W-1:0] cmp;
        cwp_dir_e     dir;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic [W-1:0] in_last;

    // highest count of a frame; a zero period folds to one count
    assign in_last = (per_i == '0) ? '0 : (per_i - ONE);

    always_comb begin
        st_d = st_q;
        if (rst || load_i) begin
            st_d.last = in_last;
            st_d.cmp  = cmp_i;
            st_d.dir  = dir_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cur_last_o = st_q.last;
    assign cur_cmp_o  = st_q.cmp;
    assign cur_dir_o  = st_q.dir;
    assign nxt_last_o = st_d.last;
    assign nxt_cmp_o  = st_d.cmp;
    assign nxt_dir_o  = st_d.dir;
endmodule

// File: rtl/cwp_counter.sv
module cwp_counter
    import cwp_pkg::*;
#(
    parameter int unsigned W = CWP_CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_i,
    input  logic [W-1:0] cur_last_i,
    input  cwp_dir_e     cur_dir_i,
    input  logic [W-1:0] nxt_last_i,
    input  cwp_dir_e     nxt_dir_i,
    output logic [W-1:0] cnt_q_o,
    output logic [W-1:0] cnt_d_o,
    output logic         reload_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    at_term;
    logic [W-1:0] start_val;

    assign at_term   = (cur_dir_i == CWP_DIR_DOWN) ? (st_q.cnt == '0)
                                                   : (st_q.cnt == cur_last_i);
    assign reload_o  = step_i & at_term;
    assign start_val = (nxt_dir_i == CWP_DIR_DOWN) ? nxt_last_i : '0;

    always_comb begin
        st_d = st_q;
        if (rst || reload_o) begin
            st_d.cnt = start_val;
        end else if (step_i) begin
            if (cur_dir_i == CWP_DIR_DOWN) st_d.cnt = st_q.cnt - ONE;
            else                           st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_q_o = st_q.cnt;
    assign cnt_d_o = st_d.cnt;
endmodule

// File: rtl/cwp_out_stage.sv
module cwp_out_stage
    import cwp_pkg::*;
#(
    parameter int unsigned W = CWP_CNT_W
) (
    input  logic         clk,
    input  logic [W-1:0] cnt_d_i,
    input  logic [W-1:0] nxt_last_i,
    input  logic [W-1:0] nxt_cmp_i,
    input  cwp_dir_e     nxt_dir_i,
    output logic         win_o,
    output logic         tc_o
);
    typedef struct packed {
        logic win;
        logic tc;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.win = (cnt_d_i < nxt_cmp_i);
        st_d.tc  = (nxt_dir_i == CWP_DIR_DOWN) ? (cnt_d_i == '0)
                                               : (cnt_d_i == nxt_last_i);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign win_o = st_q.win;
    assign tc_o  = st_q.tc;
endmodule

// File: rtl/cwp_pulse_gen.sv
module cwp_pulse_gen
    import cwp_pkg::*;
#(
    parameter int unsigned CNT_W = CWP_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_in,
    input  logic             dir_down,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_cmp,
    output logic             win_o,
    output logic             tc_o
);
    logic             rise;
    logic             reload;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] last_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] last_n;
    logic [CNT_W-1:0] cmp_n;
    cwp_dir_e         dir_q_e;
    cwp_dir_e         dir_n_e;
    logic             dir_q;

    cwp_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (cnt_in),
        .rise_o (rise)
    );

    cwp_cfg_hold #(.W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .load_i     (reload),
        .per_i      (cfg_period),
        .cmp_i      (cfg_cmp),
        .dir_i      (cwp_dir_e'(dir_down)),
        .cur_last_o (last_q),
        .cur_cmp_o  (cmp_q),
        .cur_dir_o  (dir_q_e),
        .nxt_last_o (last_n),
        .nxt_cmp_o  (cmp_n),
        .nxt_dir_o  (dir_n_e)
    );

    cwp_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .step_i     (rise),
        .cur_last_i (last_q),
        .cur_dir_i  (dir_q_e),
        .nxt_last_i (last_n),
        .nxt_dir_i  (dir_n_e),
        .cnt_q_o    (cnt_q),
        .cnt_d_o    (cnt_d),
        .reload_o   (reload)
    );

    cwp_out_stage #(.W(CNT_W)) u_out (
        .clk        (clk),
        .cnt_d_i    (cnt_d),
        .nxt_last_i (last_n),
        .nxt_cmp_i  (cmp_n),
        .nxt_dir_i  (dir_n_e),
        .win_o      (win_o),
        .tc_o       (tc_o)
    );

    assign dir_q = dir_q_e;
endmodule

// File: rtl/cwp_checker.sv
module cwp_checker #(
    parameter int unsigned W = 24
) (
    input logic         clk,
    input logic         rst,
    input logic         cnt_in,
    input logic         rise,
    input logic         reload,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] last_q,
    input logic [W-1:0] cmp_q,
    input logic         dir_q,
    input logic         win_o,
    input logic         tc_o
);
    logic armed_q = 1'b0;

    always_ff @(posedge clk) begin
        armed_q <= armed_q | rst;
    end

    AST_NO_STEP_ON_LEVEL: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (cnt_in && $past(cnt_in)) |=> ##1 $stable(cnt_q)); // R2

    AST_RELOAD_UP_ZERO: assert property (@(posedge clk) disable iff (rst || !armed_q)
        reload |=> (dir_q != 1'b0) || (cnt_q == '0)); // R3

    AST_RELOAD_DOWN_TOP: assert property (@(posedge clk) disable iff (rst || !armed_q)
        reload |=> (dir_q != 1'b1) || (cnt_q == last_q)); // R4

    AST_TC_AT_TERMINAL: assert property (@(posedge clk) disable iff (rst || !armed_q)
        tc_o |-> (dir_q ? (cnt_q == '0) : (cnt_q == last_q))); // R5

    AST_WIN_NEVER_ZERO_CMP: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (cmp_q == '0) |-> !win_o); // R8

    AST_WIN_ALWAYS_FULL_CMP: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (cmp_q > last_q) |-> win_o); // R8

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !reload |=> $stable(cmp_q) && $stable(last_q) && $stable(dir_q)); // R7

    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !rise |=> $stable(win_o) && $stable(tc_o)); // R9

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst || !armed_q)
        cnt_q <= last_q); // R10
endmodule

bind cwp_pulse_gen cwp_checker #(.W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cnt_in (cnt_in),
    .rise   (rise),
    .reload (reload),
    .cnt_q  (cnt_q),
    .last_q (last_q),
    .cmp_q  (cmp_q),
    .dir_q  (dir_q),
    .win_o  (win_o),
    .tc_o   (tc_o)
);

// File: tb/tb_cwp_pulse_gen.sv
module tb_cwp_pulse_gen;
    localparam int W = 24;
    localparam int NV = 7;
    localparam int V_DIR [NV] = '{0, 1, 0, 1, 0, 1, 0};
    localparam int V_PER [NV] = '{10, 10, 1, 5, 6, 7, 0};
    localparam int V_CMP [NV] = '{3, 3, 1, 0, 9, 7, 0};
    localparam int V_STP [NV] = '{25, 25, 5, 12, 14, 16, 4};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cnt_in = 1'b0;
    logic         dir_down = 1'b0;
    logic [W-1:0] cfg_period = '0;
    logic [W-1:0] cfg_cmp = '0;
    logic         win_o;
    logic         tc_o;

    int n_chk = 0;
    int n_fail = 0;
    int m_cnt, m_last, m_cmp, m_dir;
    bit done = 0;

    always #5 clk = ~clk;

    cwp_pulse_gen #(.CNT_W(W)) dut (
        .clk(clk), .rst(rst), .cnt_in(cnt_in), .dir_down(dir_down),
        .cfg_period(cfg_period), .cfg_cmp(cfg_cmp), .win_o(win_o), .tc_o(tc_o)
    );

    task automatic model_load();
        m_last = (cfg_period == '0) ? 0 : int'(cfg_period) - 1;
        m_cmp  = int'(cfg_cmp);
        m_dir  = int'(dir_down);
        m_cnt  = (m_dir != 0) ? m_last : 0;
    endtask

    task automatic model_step();
        int term;
        term = (m_dir != 0) ? 0 : m_last;
        if (m_cnt == term) model_load();
        else if (m_dir != 0) m_cnt = m_cnt - 1;
        else m_cnt = m_cnt + 1;
    endtask

    task automatic check(input string tag);
        logic ew, et;
        ew = (m_cnt < m_cmp);
        et = (m_cnt == ((m_dir != 0) ? 0 : m_last));
        n_chk++;
        if (win_o !== ew || tc_o !== et) begin
            n_fail++;
            $display("FAIL %s: win=%0b tc=%0b expected win=%0b tc=%0b (count %0d)",
                     tag, win_o, tc_o, ew, et, m_cnt);
        end
    endtask

    task automatic set_cfg(input int d, input int p, input int c);
        dir_down   = d[0];
        cfg_period = W'(p);
        cfg_cmp    = W'(c);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cnt_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_load();
        @(negedge clk);
    endtask

    task automatic toggle();
        cnt_in = 1'b1;
        @(negedge clk);
        cnt_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_step();
        toggle();
        model_step();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // vector table: reset state, then several frames per configuration
        for (int v = 0; v < NV; v++) begin
            set_cfg(V_DIR[v], V_PER[v], V_CMP[v]);
            do_reset();
            check("R1 reset state");
            for (int s = 0; s < V_STP[v]; s++) begin
                do_step();
                if (V_PER[v] == 0)        check("R10 zero period");
                else if (V_CMP[v] == 0 || V_CMP[v] >= V_PER[v])
                                          check("R8 constant window");
                else if (V_DIR[v] != 0)   check("R4 R5 R6 down frame");
                else                      check("R3 R5 R6 up frame");
            end
        end

        // R2: held level counts once only; idle keeps outputs (R9)
        set_cfg(0, 4, 2);
        do_reset();
        cnt_in = 1'b1;
        repeat (10) @(negedge clk);
        model_step();
        check("R2 level held high");
        cnt_in = 1'b0;
        repeat (10) @(negedge clk);
        check("R9 idle low");
        do_step();
        check("R2 next edge counts");

        // R1: toggling input while reset is held
        set_cfg(1, 6, 2);
        do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (4) toggle();
        rst = 1'b0;
        @(negedge clk);
        check("R1 steps ignored in reset");

        // R7: mid-frame change applies after the reload
        set_cfg(0, 5, 2);
        do_reset();
        do_step();
        set_cfg(1, 3, 3);
        for (int s = 0; s < 9; s++) begin
            do_step();
            check("R7 mid-frame config");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule